// File: doc/BRIEF.md
# External Data Access Monitor with Permit Timer

This block listens to the external bus of an 8-bit microcontroller that has no wait states. It brings the address latch strobe, the program-store enable and the read and write strobes into the local clock domain, and it latches the low address byte from the multiplexed address/data port. From this it keeps one permit flag. Other bus masters may use the shared DRAM only while that flag is high.

The CPU cannot stall, so the flag has to drop before the CPU makes an external data access. The block watches the instruction fetch stream for the opcodes that move data to or from external memory. When such an opcode has been fetched, the permit flag is withdrawn. It returns when the awaited read or write strobe ends. If that access never comes, it returns after a fixed timeout of 31 clocks.

Top module: `xmon_top`

## Requirements
- R1: After reset, `permit` is 1, `addrLow` is 0, `aleSync` is 0, and `psenNSync`, `rdNSync` and `wrNSync` are 1.
- R2: Each control input passes through two flip-flop stages. A change on a raw input shows on its synchronized output two clocks later and not after one.
- R3: On a falling edge of the synchronized ALE, `addrLow` takes the value on the port. It shows three clocks after the raw ALE falls, and it holds its value at all other times.
- R4: When the synchronized program-store enable rises (the fetch ends), the port byte is sampled. If that byte is one of 0xE0, 0xE2, 0xE3, 0xF0, 0xF2 or 0xF3, `permit` goes to 0 three clocks after the raw strobe rises.
- R5: A fetch of any other byte leaves `permit` as it was.
- R6: With no access after a move opcode, `permit` stays 0 for exactly 31 clocks and then returns to 1.
- R7: When the synchronized RD or WR rises while an access is pending, `permit` returns to 1 three clocks after the raw strobe rises.
- R8: A move opcode fetched while an access is already pending restarts the 31-clock timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| aleRaw | input | 1 | Address latch enable from the CPU, unsynchronized |
| psenNRaw | input | 1 | Program-store enable from the CPU, active low, unsynchronized |
| rdNRaw | input | 1 | External data read strobe, active low, unsynchronized |
| wrNRaw | input | 1 | External data write strobe, active low, unsynchronized |
| adRaw | input | 8 | Multiplexed low address / data port |
| aleSync | output | 1 | Synchronized ALE |
| psenNSync | output | 1 | Synchronized program-store enable |
| rdNSync | output | 1 | Synchronized read strobe |
| wrNSync | output | 1 | Synchronized write strobe |
| addrLow | output | 8 | Latched low address byte |
| permit | output | 1 | High when other masters may use the shared memory |

## Verification
Fetch cycles carry random opcode bytes, with the six move opcodes mixed in often. This separates the recognized set from near-miss codes, such as 0xE1 and 0xF1, that must leave the permit up. After each withdrawal the bench either completes the access with RD or WR, or stays silent. This tells release by strobe apart from release by timeout. Directed sequences cover the following:
- the exact 31-clock window;
- a restart caused by a second move opcode at clock 20;
- the two-stage latency of the strobes;
- the address byte being held while ALE stays high.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

  // Event strobes from the datapath to the control.
  typedef struct packed {
    logic moveSeen;   // an external-move opcode has just been fetched
    logic accessEnd;  // synchronized RD or WR has just risen
  } busEvt_t;

  function automatic logic isXmove(input logic [7:0] op);
    return (op == 8'hE0) || (op == 8'hE2) || (op == 8'hE3) ||
           (op == 8'hF0) || (op == 8'hF2) || (op == 8'hF3);
  endfunction

endpackage

// File: rtl/xmon_datapath.sv
module xmon_datapath
  import xmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aleRaw,
  input  logic              psenNRaw,
  input  logic              rdNRaw,
  input  logic              wrNRaw,
  input  logic [ADDR_W-1:0] adRaw,
  output logic              aleSync,
  output logic              psenNSync,
  output logic              rdNSync,
  output logic              wrNSync,
  output logic [ADDR_W-1:0] addrLow,
  output busEvt_t           evt
);

  // Control bit order: 0 = ALE, 1 = PSEN_n, 2 = RD_n, 3 = WR_n
  localparam int         CTL_W    = 4;
  localparam logic [3:0] CTL_IDLE = 4'b1110;

  logic [CTL_W-1:0]  ctlRaw;
  logic [CTL_W-1:0]  ctlStage [SYNC_STAGES];
  logic [ADDR_W-1:0] adStage  [SYNC_STAGES];
  logic [CTL_W-1:0]  ctlSync, ctlPrev;
  logic [ADDR_W-1:0] adSync;
  logic              aleFall, fetchEnd, rdRise, wrRise;

  assign ctlRaw = {wrNRaw, rdNRaw, psenNRaw, aleRaw};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ctlStage[g] <= CTL_IDLE;
          adStage[g]  <= '0;
        end else begin
          ctlStage[g] <= ctlRaw;
          adStage[g]  <= adRaw;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ctlStage[g] <= CTL_IDLE;
          adStage[g]  <= '0;
        end else begin
          ctlStage[g] <= ctlStage[g-1];
          adStage[g]  <= adStage[g-1];
        end
      end
    end
  end

  assign ctlSync = ctlStage[SYNC_STAGES-1];
  assign adSync  = adStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlPrev <= CTL_IDLE;
    else       ctlPrev <= ctlSync;
  end

  assign aleFall  =  ctlPrev[0] & ~ctlSync[0];
  assign fetchEnd = ~ctlPrev[1] &  ctlSync[1];
  assign rdRise   = ~ctlPrev[2] &  ctlSync[2];
  assign wrRise   = ~ctlPrev[3] &  ctlSync[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        addrLow <= '0;
    else if (aleFall) addrLow <= adSync;
  end

  assign evt.moveSeen  = fetchEnd & isXmove(adSync[7:0]);
  assign evt.accessEnd = rdRise | wrRise;

  assign aleSync   = ctlSync[0];
  assign psenNSync = ctlSync[1];
  assign rdNSync   = ctlSync[2];
  assign wrNSync   = ctlSync[3];

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !aleFall |=> $stable(addrLow));

endmodule

// File: rtl/xmon_control.sv
module xmon_control
  import xmon_pkg::*;
#(
  parameter int TIMEOUT = 31
) (
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  output logic    permit
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic             pending;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      waitCnt <= '0;
    end else if (evt.moveSeen) begin
      pending <= 1'b1;
      waitCnt <= '0;
    end else if (pending) begin
      if (evt.accessEnd || waitCnt == LAST) begin
        pending <= 1'b0;
        waitCnt <= '0;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign permit = ~pending;

  // R4
  move_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.moveSeen |=> !permit);
  // R7
  access_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!permit && evt.accessEnd && !evt.moveSeen) |=> permit);
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.moveSeen |=> waitCnt == '0);
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= LAST);

endmodule

// File: rtl/xmon_top.sv
module xmon_top
  import xmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aleRaw,
  input  logic       psenNRaw,
  input  logic       rdNRaw,
  input  logic       wrNRaw,
  input  logic [7:0] adRaw,
  output logic       aleSync,
  output logic       psenNSync,
  output logic       rdNSync,
  output logic       wrNSync,
  output logic [7:0] addrLow,
  output logic       permit
);

  busEvt_t evt;

  xmon_datapath #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(8)) u_dp (
    .clk(clk), .rstN(rstN),
    .aleRaw(aleRaw), .psenNRaw(psenNRaw), .rdNRaw(rdNRaw), .wrNRaw(wrNRaw),
    .adRaw(adRaw),
    .aleSync(aleSync), .psenNSync(psenNSync), .rdNSync(rdNSync),
    .wrNSync(wrNSync), .addrLow(addrLow), .evt(evt)
  );

  xmon_control #(.TIMEOUT(TIMEOUT)) u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .permit(permit)
  );

endmodule

// File: tb/xmon_top_tb.sv
module xmon_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       aleRaw = 1'b0, psenNRaw = 1'b1, rdNRaw = 1'b1, wrNRaw = 1'b1;
  logic [7:0] adRaw = 8'h00;
  logic       aleSync, psenNSync, rdNSync, wrNSync, permit;
  logic [7:0] addrLow;
  int         nRun = 0, nFail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  xmon_top u_dut (
    .clk(clk), .rstN(rstN), .aleRaw(aleRaw), .psenNRaw(psenNRaw),
    .rdNRaw(rdNRaw), .wrNRaw(wrNRaw), .adRaw(adRaw),
    .aleSync(aleSync), .psenNSync(psenNSync), .rdNSync(rdNSync),
    .wrNSync(wrNSync), .addrLow(addrLow), .permit(permit)
  );

  function automatic bit expMove(input logic [7:0] op);
    return op inside {8'hE0, 8'hE2, 8'hE3, 8'hF0, 8'hF2, 8'hF3};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Address phase and opcode fetch; returns three clocks after PSEN release.
  task automatic fetch(input logic [7:0] addr, input logic [7:0] op);
    aleRaw = 1'b1; adRaw = addr; tick(2);
    aleRaw = 1'b0; tick(3);
    check("R3 address latch", addrLow, addr);
    psenNRaw = 1'b0; adRaw = op; tick(3);
    psenNRaw = 1'b1; tick(3);
  endtask

  task automatic access(input bit isWrite);
    if (isWrite) wrNRaw = 1'b0; else rdNRaw = 1'b0;
    tick(3);
    if (isWrite) wrNRaw = 1'b1; else rdNRaw = 1'b1;
    tick(2);
    check("R7 permit low before release", permit, 1'b0);
    tick(1);
    check("R7 permit after strobe end", permit, 1'b1);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    tick(3);
    // R1 reset state
    check("R1 permit", permit, 1'b1);
    check("R1 addrLow", addrLow, 8'h00);
    check("R1 strobes", {aleSync, psenNSync, rdNSync, wrNSync}, 4'b0111);
    rstN = 1'b1; tick(2);

    // R2 two-stage latency
    aleRaw = 1'b1; adRaw = 8'h5A; tick(1);
    check("R2 ale after 1", aleSync, 1'b0);
    tick(1);
    check("R2 ale after 2", aleSync, 1'b1);
    adRaw = 8'h33; tick(4);
    check("R3 hold while ALE high", addrLow, 8'h00);
    aleRaw = 1'b0; tick(3);
    check("R3 latch on fall", addrLow, 8'h33);
    rdNRaw = 1'b0; tick(1);
    check("R2 rd after 1", rdNSync, 1'b1);
    tick(1);
    check("R2 rd after 2", rdNSync, 1'b0);
    rdNRaw = 1'b1; tick(3);
    check("R5 stray read keeps permit", permit, 1'b1);

    // R4/R6 exact timeout window
    fetch(8'h10, 8'hF0);
    check("R4 permit dropped", permit, 1'b0);
    tick(30);
    check("R6 still low at 30", permit, 1'b0);
    tick(1);
    check("R6 high at 31", permit, 1'b1);

    // R8 restart
    fetch(8'h20, 8'hE2);
    tick(20 - 11);
    fetch(8'h21, 8'hE3);
    check("R8 low after refetch", permit, 1'b0);
    tick(30);
    check("R8 restarted window", permit, 1'b0);
    tick(1);
    check("R8 expiry after restart", permit, 1'b1);

    // R5 near-miss codes
    fetch(8'h30, 8'hE1);
    check("R5 E1 ignored", permit, 1'b1);
    fetch(8'h31, 8'hF1);
    check("R5 F1 ignored", permit, 1'b1);

    // R7 write release
    fetch(8'h40, 8'hF2);
    check("R4 F2 drops", permit, 1'b0);
    access(1'b1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] op, ad;
      logic [7:0] moves [6] = '{8'hE0, 8'hE2, 8'hE3, 8'hF0, 8'hF2, 8'hF3};
      ad = 8'($urandom);
      op = ($urandom % 2) ? moves[$urandom % 6] : 8'($urandom);
      fetch(ad, op);
      check(expMove(op) ? "R4 random move" : "R5 random other", permit, !expMove(op));
      if (!permit) begin
        case ($urandom % 3)
          0: access(1'b0);
          1: access(1'b1);
          default: begin tick(31); check("R6 random timeout", permit, 1'b1); end
        endcase
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule